// File: doc/BRIEF.md
# Oscillator Race Response Bit

This block yields one response bit by racing two free-running oscillator signals. An 8-bit challenge carries two 4-bit fields. The low field picks one of sixteen oscillator inputs for side A, and the high field picks one for side B. Each picked signal is brought into the system clock domain. Each side then counts rising edges in its own saturating counter.

The side whose counter first reaches the all-ones value wins. When A wins the response is 1. When B wins, or when both sides fill on the same cycle, the response is 0. A finish flag rises once the race is decided. From then on the counters stop and the result holds until the next synchronous reset. The challenge is captured while reset is held, so a new challenge takes effect only when a new race begins.

The oscillators themselves sit outside this block. In a bench they are plain square waves. The oscillators are expected to run well below half the system clock rate, so that the block sees every rising edge.

Top module: `ro_race_bit`

## Requirements
- R1: While reset is held and on the first cycle after it, finish_o is 0 and bit_o is 0, and both edge counters are cleared.
- R2: Side A counts oscillator osc_i[sel_i[3:0]] and side B counts osc_i[sel_i[7:4]]; the field value is the input index.
- R3: Each selected signal passes through a two-flop synchronizer, and its counter advances by exactly one for each synchronized rising edge.
- R4: If the side A counter reaches all ones on a cycle where side B has not, bit_o becomes 1.
- R5: If the side B counter reaches all ones while side A has not, bit_o becomes 0.
- R6: finish_o rises on the clock edge after the first counter reaches all ones, and it stays high until reset.
- R7: Once finish_o is high, neither counter changes and bit_o holds its value.
- R8: If both counters reach all ones on the same cycle, bit_o is 0 and finish_o still rises.
- R9: When both fields select the same oscillator, the race still completes, with bit_o 0 under the tie rule of R8.
- R10: The challenge is sampled only while reset is high; changes on sel_i after reset is released do not alter the race or its result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_i | input | 1 | Synchronous reset, active high; also loads the challenge |
| osc_i | input | NUM_OSC (16) | Free-running oscillator signals |
| sel_i | input | 2*SEL_W (8) | Challenge: low field selects side A, high field selects side B |
| finish_o | output | 1 | Race decided |
| bit_o | output | 1 | Response bit, 1 when side A wins |

## Verification
The bench builds the block with sixteen oscillators and CNT_W = 4. A counter then fills after fifteen edges, so a race takes a few hundred cycles. That small width makes it possible to run all 256 challenge pairs, same-index ties included, with the oscillators restarted in phase at each reset. Given that phase alignment and half-periods that grow with the index, the lower index always wins, and the exact finish cycle can be worked out from the winner's period. That allows a window check on the finish latency, a hold check after finish, and a run where the select lines are changed in the middle of a race.

// File: rtl/ro_race_pkg.sv
package ro_race_pkg;
  // Outcome of the race on the cycle a decision is made: A wins only alone.
  function automatic logic race_outcome(input logic a_full, input logic b_full);
    return a_full & ~b_full;
  endfunction

  // A decision is taken on the first cycle either side is full.
  function automatic logic race_decides(input logic a_full, input logic b_full);
    return a_full | b_full;
  endfunction
endpackage

// File: rtl/osc_select.sv
module osc_select #(
  parameter int NUM_OSC = 16,
  parameter int SEL_W   = (NUM_OSC > 1) ? $clog2(NUM_OSC) : 1
) (
  input  logic [NUM_OSC-1:0] osc_i,
  input  logic [SEL_W-1:0]   sel_i,
  output logic               osc_o
);
  always_comb begin
    osc_o = 1'b0;
    for (int k = 0; k < NUM_OSC; k++) begin
      if (sel_i == SEL_W'(k)) osc_o = osc_i[k];
    end
  end
endmodule

// File: rtl/edge_race_counter.sv
module edge_race_counter #(
  parameter int CNT_W       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_i,
  input  logic             osc_i,
  input  logic             freeze_i,
  output logic             rise_o,
  output logic             full_o,
  output logic [CNT_W-1:0] count_o
);
  localparam logic [CNT_W-1:0] ALL_ONES = '1;

  logic [SYNC_STAGES-1:0] sync_q;
  logic                   prev_q;
  logic                   synced;

  function automatic logic [CNT_W-1:0] bump(input logic [CNT_W-1:0] c);
    return (c == ALL_ONES) ? c : c + CNT_W'(1);
  endfunction

  assign synced = sync_q[SYNC_STAGES-1];
  assign rise_o = synced & ~prev_q;
  assign full_o = (count_o == ALL_ONES);

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      sync_q  <= '0;
      prev_q  <= 1'b0;
      count_o <= '0;
    end else begin
      sync_q  <= {sync_q[SYNC_STAGES-2:0], osc_i};
      prev_q  <= synced;
      if (rise_o && !freeze_i) count_o <= bump(count_o);
    end
  end

  // R3: the count moves only upward, one step at a time
  p_step_one_r3: assert property (@(posedge clk_i) disable iff (rst_i)
    !$stable(count_o) |-> (count_o == $past(count_o) + CNT_W'(1)));

  // R7: a frozen counter does not move
  p_frozen_r7: assert property (@(posedge clk_i) disable iff (rst_i)
    freeze_i |=> $stable(count_o));
endmodule

// File: rtl/race_arbiter.sv
module race_arbiter
  import ro_race_pkg::*;
(
  input  logic clk_i,
  input  logic rst_i,
  input  logic a_full_i,
  input  logic b_full_i,
  output logic done_o,
  output logic bit_o
);
  logic decide_now;
  assign decide_now = !done_o && race_decides(a_full_i, b_full_i);

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      done_o <= 1'b0;
      bit_o  <= 1'b0;
    end else if (decide_now) begin
      done_o <= 1'b1;
      bit_o  <= race_outcome(a_full_i, b_full_i);
    end
  end

  // R6: finish is sticky
  p_finish_sticky_r6: assert property (@(posedge clk_i) disable iff (rst_i)
    done_o |=> done_o);
  // R6: the first full counter raises finish on the next edge
  p_finish_rise_r6: assert property (@(posedge clk_i) disable iff (rst_i)
    (a_full_i || b_full_i) |=> done_o);
  // R7: result holds once decided
  p_bit_hold_r7: assert property (@(posedge clk_i) disable iff (rst_i)
    done_o |=> $stable(bit_o));
  // R4: A alone full gives 1
  p_a_wins_r4: assert property (@(posedge clk_i) disable iff (rst_i)
    (!done_o && a_full_i && !b_full_i) |=> bit_o);
  // R5: B alone full gives 0
  p_b_wins_r5: assert property (@(posedge clk_i) disable iff (rst_i)
    (!done_o && b_full_i && !a_full_i) |=> !bit_o);
  // R8: tie gives 0
  p_tie_zero_r8: assert property (@(posedge clk_i) disable iff (rst_i)
    (!done_o && a_full_i && b_full_i) |=> (!bit_o && done_o));
endmodule

// File: rtl/ro_race_bit.sv
module ro_race_bit #(
  parameter int NUM_OSC     = 16,
  parameter int SEL_W       = 4,
  parameter int CNT_W       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk_i,
  input  logic               rst_i,
  input  logic [NUM_OSC-1:0] osc_i,
  input  logic [2*SEL_W-1:0] sel_i,
  output logic               finish_o,
  output logic               bit_o
);
  localparam int SIDES = 2;

  logic [SEL_W-1:0] sel_q [SIDES];
  logic [SIDES-1:0] side_osc, side_rise, side_full;
  logic [CNT_W-1:0] side_count [SIDES];
  logic             freeze;

  // R10: challenge captured only while reset is held
  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      sel_q[0] <= sel_i[SEL_W-1:0];
      sel_q[1] <= sel_i[2*SEL_W-1:SEL_W];
    end
  end

  assign freeze = finish_o;

  for (genvar s = 0; s < SIDES; s++) begin : g_side
    osc_select #(.NUM_OSC(NUM_OSC), .SEL_W(SEL_W)) u_sel (
      .osc_i (osc_i),
      .sel_i (sel_q[s]),
      .osc_o (side_osc[s])
    );
    edge_race_counter #(.CNT_W(CNT_W), .SYNC_STAGES(SYNC_STAGES)) u_cnt (
      .clk_i    (clk_i),
      .rst_i    (rst_i),
      .osc_i    (side_osc[s]),
      .freeze_i (freeze),
      .rise_o   (side_rise[s]),
      .full_o   (side_full[s]),
      .count_o  (side_count[s])
    );
  end

  race_arbiter u_arb (
    .clk_i    (clk_i),
    .rst_i    (rst_i),
    .a_full_i (side_full[0]),
    .b_full_i (side_full[1]),
    .done_o   (finish_o),
    .bit_o    (bit_o)
  );

  // R10: the held challenge never changes outside reset
  p_sel_hold_r10: assert property (@(posedge clk_i) disable iff (rst_i)
    !$past(rst_i) |-> (sel_q[0] == $past(sel_q[0]) && sel_q[1] == $past(sel_q[1])));
  // R1: counters leave reset cleared
  p_reset_clear_r1: assert property (@(posedge clk_i)
    $past(rst_i) |-> (side_count[0] == '0 && side_count[1] == '0 && !finish_o));
  // R9: same selection means identical counts
  p_same_sel_r9: assert property (@(posedge clk_i) disable iff (rst_i)
    (sel_q[0] == sel_q[1] && !$past(rst_i)) |-> (side_count[0] == side_count[1]));
endmodule

// File: tb/ro_race_bit_tb_top.sv
module ro_race_bit_tb_top;
  localparam int NUM_OSC = 16;
  localparam int SEL_W   = 4;
  localparam int CNT_W   = 4;
  localparam int EDGES   = (1 << CNT_W) - 1;

  logic               clk = 1'b0;
  logic               rst = 1'b1;
  logic [NUM_OSC-1:0] osc = '0;
  logic [2*SEL_W-1:0] sel = '0;
  logic               finish, bitv;
  int                 checks = 0, failures = 0;
  int                 osc_cnt [NUM_OSC];

  always #4 clk = ~clk;

  ro_race_bit #(.NUM_OSC(NUM_OSC), .SEL_W(SEL_W), .CNT_W(CNT_W)) dut_i (
    .clk_i(clk), .rst_i(rst), .osc_i(osc), .sel_i(sel),
    .finish_o(finish), .bit_o(bitv)
  );

  function automatic int half_period(input int idx);
    return 2 + idx;
  endfunction

  // Oscillators restart in phase with each reset; index i toggles every 2+i cycles.
  always @(negedge clk) begin
    for (int i = 0; i < NUM_OSC; i++) begin
      if (rst) begin
        osc_cnt[i] = 0;
        osc[i] <= 1'b0;
      end else if (osc_cnt[i] == half_period(i) - 1) begin
        osc_cnt[i] = 0;
        osc[i] <= ~osc[i];
      end else begin
        osc_cnt[i] = osc_cnt[i] + 1;
      end
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Runs one race; returns cycles from release to finish (-1 on timeout).
  task automatic race(input int a, input int b, input int swap_at, output int n);
    @(negedge clk);
    rst = 1'b1;
    sel = {SEL_W'(b), SEL_W'(a)};
    repeat (3) @(negedge clk);
    rst = 1'b0;
    n = -1;
    for (int c = 1; c <= 2000; c++) begin
      @(negedge clk);
      if (c == swap_at) sel = {SEL_W'(a), SEL_W'(b)};
      if (finish) begin n = c; break; end
    end
  endtask

  initial begin
    int n, exp_bit, win, lo;
    repeat (3) @(negedge clk);
    // R1: reset state
    check(finish == 1'b0, "R1 finish in reset", finish, 0);
    check(bitv == 1'b0, "R1 bit in reset", bitv, 0);
    rst = 1'b0;
    @(negedge clk);
    check(finish == 1'b0, "R1 finish after release", finish, 0);

    // R2 R4 R5 R8 R9: all challenge pairs
    for (int a = 0; a < NUM_OSC; a++) begin
      for (int b = 0; b < NUM_OSC; b++) begin
        race(a, b, 0, n);
        exp_bit = (a < b) ? 1 : 0;
        win = (a < b) ? a : b;
        lo = (2 * EDGES - 1) * half_period(win);
        check(n >= 0, "R9/R6 race completes", n, lo);
        check(bitv == exp_bit[0], (a == b) ? "R9 R8 tie bit" :
              (a < b) ? "R4 R2 side A wins" : "R5 R2 side B wins", bitv, exp_bit);
        // R3: finish timing follows edge count through the synchronizer
        check(n >= lo && n <= lo + 8, "R3 finish latency", n, lo + 4);
      end
    end

    // R7: result and finish hold after the decision
    race(2, 7, 0, n);
    repeat (200) @(negedge clk);
    check(finish == 1'b1, "R7 R6 finish held", finish, 1);
    check(bitv == 1'b1, "R7 bit held", bitv, 1);
    race(9, 1, 0, n);
    repeat (200) @(negedge clk);
    check(bitv == 1'b0, "R7 bit held low", bitv, 0);

    // R10: select swapped mid-race has no effect
    race(3, 12, 20, n);
    check(bitv == 1'b1, "R10 swap ignored A", bitv, 1);
    check(n >= 29 * half_period(3) && n <= 29 * half_period(3) + 8, "R10 latency", n, 29 * half_period(3) + 4);
    race(12, 3, 20, n);
    check(bitv == 1'b0, "R10 swap ignored B", bitv, 0);

    // R1: reset clears a decided race
    @(negedge clk); rst = 1'b1;
    @(negedge clk); @(negedge clk);
    check(finish == 1'b0 && bitv == 1'b0, "R1 reset clears result", {finish, bitv}, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    failures++;
    checks++;
    $display("FAIL watchdog R6 actual=%0d expected=%0d", 0, 1);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule